// File: doc/BRIEF.md
# Set-Associative Cache Tag Lookup

This block is the tag side of a four-way set-associative unified cache with 64-byte lines. A lookup presents a line address; the block reads the four tag entries of the selected set in one cycle, verifies each entry's parity, and compares the stored tags against the address. It returns a one-hot way select, a hit flag, the coherence state of the hitting line and a tag error flag. On a miss it also names the way to replace. The choice prefers an empty way and otherwise uses random bits stored with the lines. Ways that software has locked are never chosen. The tag arrays are register arrays inside the block, filled through a plain write port.

Lookups enter on a valid/ready handshake and results leave on a second valid/ready handshake. The result register is the only buffer. A lookup is accepted when the result register is empty or is being drained in the same cycle (`lk_ready = !rs_valid || rs_ready`). While a result waits with `rs_ready` low, it holds steady and no new lookup is taken. The way lock mask and the write port are plain control inputs with no handshake. The default build has 64 sets for elaboration; the full 512 kB configuration sets `SET_BITS` to 11 (2048 sets).

Top module: `sa_tag_lookup`

## Requirements
- R1: An accepted lookup yields its result one cycle later. The line address is {tag, set}, with the set in the low `SET_BITS` bits. A hit marks exactly the matching way in `rs_way` and reports that way's state on `rs_state`. State codes are 0 invalid, 1 shared, 2 exclusive, 3 owned and 4 modified. On a miss, `rs_way` is zero and `rs_state` is 0.
- R2: An entry whose state is invalid (0) or reserved (5 to 7) never hits, even if its tag matches.
- R3: Each entry stores two check bits. Bit 0 is the XOR of all tag bits and bit 1 is the XOR of the three state bits. A way whose stored check bits disagree cannot hit. If any way of the set disagrees, `rs_par_err` is raised.
- R4: On a miss, if any unlocked way is invalid, reserved or fails parity, the lowest-numbered such way is the victim.
- R5: On a miss with no such way, a start index is formed as the XOR of the four ways' 2-bit random fields. The victim is the first unlocked way found from that index upward, wrapping modulo 4.
- R6: A locked way (`way_lock` bit set) is never the victim. A miss with all ways locked raises `rs_no_alloc` and leaves `rs_victim` zero.
- R7: On a hit, `rs_victim` is zero and `rs_no_alloc` is low, whatever the lock mask is. Locks do not stop a way from hitting.
- R8: `lk_ready` equals `!rs_valid || rs_ready`. While `rs_valid` is high and `rs_ready` is low, every result output holds its value.
- R9: Reset clears `rs_valid` and makes every entry invalid, with tag 0 and check bits 0. A lookup after reset therefore misses with no parity error and picks way 0.
- R10: `wr_en` writes the tag, state, check bits and random field of the entry at (`wr_set`, `wr_way`). A lookup accepted in any later cycle sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | ADDR_W-OFF_BITS | Line address {tag, set} |
| way_lock | input | WAYS | Ways excluded from replacement |
| wr_en | input | 1 | Write one tag entry |
| wr_set | input | SET_BITS | Set of the entry written |
| wr_way | input | log2(WAYS) | Way of the entry written |
| wr_tag | input | TAG_W | Tag written |
| wr_state | input | 3 | Coherence state written |
| wr_par | input | 2 | Check bits written |
| wr_rnd | input | log2(WAYS) | Random field written |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result consumer ready |
| rs_hit | output | 1 | Lookup hit |
| rs_way | output | WAYS | One-hot hitting way |
| rs_state | output | 3 | State of the hitting line |
| rs_par_err | output | 1 | Check-bit mismatch in the set |
| rs_victim | output | WAYS | One-hot replacement way on a miss |
| rs_no_alloc | output | 1 | Miss with every way locked |

## Verification
The bench fills sets with known contents and then probes several hazards. These are a tag that matches an empty or reserved-state entry, a hitting line beside a corrupted way, and a corrupted way that still matches its own tag. A design that trusted the state or the check bits would report false hits, and one that scoped the error flag to the hitting way would hide the fault. Victim checks cover a locked empty way, a locked random start that must wrap to the next way, and a fully locked set. These expose a victim picker that ignores locks or fails to wrap. Stalled results and a reset in the middle of the run are checked for outputs that drift under back-pressure and for arrays that keep stale hits.

// File: rtl/satl_pkg.sv
`timescale 1ns/1ps
package satl_pkg;
  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_SHR = 3'd1,
    ST_EXC = 3'd2,
    ST_OWN = 3'd3,
    ST_MOD = 3'd4
  } line_state_e;

  // Codes 1..4 are live; 0 and the reserved codes 5..7 are not.
  function automatic logic state_live(input logic [2:0] s);
    return (s != 3'd0) && (s <= 3'd4);
  endfunction
endpackage

// File: rtl/satl_tag_store.sv
`timescale 1ns/1ps
module satl_tag_store #(
  parameter int WAYS     = 4,
  parameter int SET_BITS = 6,
  parameter int TAG_W    = 28,
  localparam int SETS    = 1 << SET_BITS,
  localparam int WIDX    = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SET_BITS-1:0]          wr_set,
  input  logic [WIDX-1:0]              wr_way,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [2:0]                   wr_state,
  input  logic [1:0]                   wr_par,
  input  logic [WIDX-1:0]              wr_rnd,
  input  logic [SET_BITS-1:0]          rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  output logic [WAYS-1:0][2:0]         rd_state,
  output logic [WAYS-1:0][1:0]         rd_par,
  output logic [WAYS-1:0][WIDX-1:0]    rd_rnd
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [2:0]       st_q  [SETS];
    logic [1:0]       par_q [SETS];
    logic [WIDX-1:0]  rnd_q [SETS];
    logic             sel;

    assign sel = wr_en && (wr_way == WIDX'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) begin
          tag_q[s] <= '0;
          st_q[s]  <= satl_pkg::ST_INV;
          par_q[s] <= '0;
          rnd_q[s] <= '0;
        end
      end else if (sel) begin
        tag_q[wr_set] <= wr_tag;
        st_q[wr_set]  <= wr_state;
        par_q[wr_set] <= wr_par;
        rnd_q[wr_set] <= wr_rnd;
      end
    end

    assign rd_tag[w]   = tag_q[rd_set];
    assign rd_state[w] = st_q[rd_set];
    assign rd_par[w]   = par_q[rd_set];
    assign rd_rnd[w]   = rnd_q[rd_set];
  end
endmodule

// File: rtl/satl_way_match.sv
`timescale 1ns/1ps
module satl_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 28
) (
  input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  input  logic [WAYS-1:0][2:0]       rd_state,
  input  logic [WAYS-1:0][1:0]       rd_par,
  input  logic [TAG_W-1:0]           lk_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic [WAYS-1:0]            bad_vec,
  output logic [WAYS-1:0]            dead_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic live;
    assign bad_vec[w]  = rd_par[w] != {^rd_state[w], ^rd_tag[w]};
    assign live        = satl_pkg::state_live(rd_state[w]);
    assign hit_vec[w]  = live && !bad_vec[w] && (rd_tag[w] == lk_tag);
    assign dead_vec[w] = !live || bad_vec[w];
  end
endmodule

// File: rtl/satl_victim.sv
`timescale 1ns/1ps
module satl_victim #(
  parameter int WAYS = 4,
  localparam int WIDX = $clog2(WAYS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WAYS-1:0]           dead_vec,
  input  logic [WAYS-1:0]           lock,
  input  logic [WAYS-1:0][WIDX-1:0] rnd,
  output logic [WAYS-1:0]           victim,
  output logic                      no_alloc
);
  logic [WAYS-1:0] free_w;
  logic [WAYS-1:0] pref;
  logic [WIDX-1:0] start;

  assign free_w = ~lock;
  assign pref   = free_w & dead_vec;

  always_comb begin
    start = '0;
    for (int w = 0; w < WAYS; w++) start = start ^ rnd[w];
  end

  always_comb begin
    logic [WIDX-1:0] idx;
    idx      = '0;
    victim   = '0;
    no_alloc = 1'b0;
    if (|pref) begin
      for (int i = WAYS - 1; i >= 0; i--)
        if (pref[i]) victim = WAYS'(1) << i;
    end else if (free_w == '0) begin
      no_alloc = 1'b1;
    end else begin
      for (int k = WAYS - 1; k >= 0; k--) begin
        idx = start + WIDX'(k);
        if (free_w[idx]) victim = WAYS'(1) << idx;
      end
    end
  end

  p_victim_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (victim & lock) == '0);
  p_victim_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(victim));
  p_empty_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|pref) |-> (|(victim & dead_vec)));
  p_noalloc_novictim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    no_alloc |-> (victim == '0 && lock == {WAYS{1'b1}}));
endmodule

// File: rtl/sa_tag_lookup.sv
`timescale 1ns/1ps
module sa_tag_lookup #(
  parameter int ADDR_W   = 40,
  parameter int OFF_BITS = 6,
  parameter int SET_BITS = 6,
  parameter int WAYS     = 4,
  localparam int TAG_W   = ADDR_W - SET_BITS - OFF_BITS,
  localparam int LA_W    = ADDR_W - OFF_BITS,
  localparam int WIDX    = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [LA_W-1:0]     lk_addr,
  input  logic [WAYS-1:0]     way_lock,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic [WIDX-1:0]     wr_way,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [2:0]          wr_state,
  input  logic [1:0]          wr_par,
  input  logic [WIDX-1:0]     wr_rnd,
  output logic                rs_valid,
  input  logic                rs_ready,
  output logic                rs_hit,
  output logic [WAYS-1:0]     rs_way,
  output logic [2:0]          rs_state,
  output logic                rs_par_err,
  output logic [WAYS-1:0]     rs_victim,
  output logic                rs_no_alloc
);
  logic [SET_BITS-1:0]          lk_set;
  logic [TAG_W-1:0]             lk_tag;
  logic [WAYS-1:0][TAG_W-1:0]   rd_tag;
  logic [WAYS-1:0][2:0]         rd_state;
  logic [WAYS-1:0][1:0]         rd_par;
  logic [WAYS-1:0][WIDX-1:0]    rd_rnd;
  logic [WAYS-1:0]              hit_vec, bad_vec, dead_vec, vic_vec;
  logic                         vic_none, hit_any, fire;
  logic [2:0]                   hit_state;

  assign lk_set   = lk_addr[SET_BITS-1:0];
  assign lk_tag   = lk_addr[LA_W-1:SET_BITS];
  assign lk_ready = !rs_valid || rs_ready;
  assign fire     = lk_valid && lk_ready;

  satl_tag_store #(.WAYS(WAYS), .SET_BITS(SET_BITS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag),
    .wr_state(wr_state), .wr_par(wr_par), .wr_rnd(wr_rnd),
    .rd_set(lk_set), .rd_tag(rd_tag), .rd_state(rd_state),
    .rd_par(rd_par), .rd_rnd(rd_rnd)
  );

  satl_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .rd_tag(rd_tag), .rd_state(rd_state), .rd_par(rd_par), .lk_tag(lk_tag),
    .hit_vec(hit_vec), .bad_vec(bad_vec), .dead_vec(dead_vec)
  );

  satl_victim #(.WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .dead_vec(dead_vec), .lock(way_lock),
    .rnd(rd_rnd), .victim(vic_vec), .no_alloc(vic_none)
  );

  assign hit_any = |hit_vec;

  always_comb begin
    hit_state = satl_pkg::ST_INV;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_state = hit_state | rd_state[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid    <= 1'b0;
      rs_hit      <= 1'b0;
      rs_way      <= '0;
      rs_state    <= satl_pkg::ST_INV;
      rs_par_err  <= 1'b0;
      rs_victim   <= '0;
      rs_no_alloc <= 1'b0;
    end else begin
      if (fire) begin
        rs_valid    <= 1'b1;
        rs_hit      <= hit_any;
        rs_way      <= hit_vec;
        rs_state    <= hit_state;
        rs_par_err  <= |bad_vec;
        rs_victim   <= hit_any ? '0 : vic_vec;
        rs_no_alloc <= !hit_any && vic_none;
      end else if (rs_ready) begin
        rs_valid <= 1'b0;
      end
    end
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_hit) && $stable(rs_way)
      && $stable(rs_state) && $stable(rs_victim) && $stable(rs_no_alloc)));
  p_hit_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit) |-> satl_pkg::state_live(rs_state));
  p_miss_noway_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_way == '0 && rs_state == satl_pkg::ST_INV));
  p_hit_novictim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit) |-> (rs_victim == '0 && !rs_no_alloc && $onehot(rs_way)));
endmodule

// File: tb/sa_tag_lookup_bench.sv
`timescale 1ns/1ps
module sa_tag_lookup_bench;
  localparam int TW = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic lk_ready;
  logic [33:0] lk_addr = '0;
  logic [3:0] way_lock = '0;
  logic wr_en = 1'b0;
  logic [5:0] wr_set = '0;
  logic [1:0] wr_way = '0;
  logic [TW-1:0] wr_tag = '0;
  logic [2:0] wr_state = '0;
  logic [1:0] wr_par = '0;
  logic [1:0] wr_rnd = '0;
  logic rs_valid;
  logic rs_ready = 1'b1;
  logic rs_hit;
  logic [3:0] rs_way;
  logic [2:0] rs_state;
  logic rs_par_err;
  logic [3:0] rs_victim;
  logic rs_no_alloc;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sa_tag_lookup u_sa_tag_lookup (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_addr(lk_addr), .way_lock(way_lock), .wr_en(wr_en), .wr_set(wr_set),
    .wr_way(wr_way), .wr_tag(wr_tag), .wr_state(wr_state), .wr_par(wr_par),
    .wr_rnd(wr_rnd), .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit),
    .rs_way(rs_way), .rs_state(rs_state), .rs_par_err(rs_par_err),
    .rs_victim(rs_victim), .rs_no_alloc(rs_no_alloc)
  );

  typedef struct packed {
    logic [5:0]    s_idx;
    logic [TW-1:0] tg;
    logic [3:0]    lk;
    logic          hit;
    logic [3:0]    way;
    logic [2:0]    st;
    logic          perr;
    logic [3:0]    vic;
    logic          na;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{6'd5,  28'h100, 4'h0, 1'b1, 4'h1, 3'd4, 1'b0, 4'h0, 1'b0}, // R1 modified
    '{6'd5,  28'h103, 4'h0, 1'b1, 4'h8, 3'd1, 1'b0, 4'h0, 1'b0}, // R1 shared
    '{6'd5,  28'h102, 4'hF, 1'b1, 4'h4, 3'd2, 1'b0, 4'h0, 1'b0}, // R7 locked hit
    '{6'd5,  28'h1FF, 4'h0, 1'b0, 4'h0, 3'd0, 1'b0, 4'h8, 1'b0}, // R5 start 3
    '{6'd5,  28'h1FF, 4'h8, 1'b0, 4'h0, 3'd0, 1'b0, 4'h1, 1'b0}, // R5 wrap
    '{6'd5,  28'h1FF, 4'hF, 1'b0, 4'h0, 3'd0, 1'b0, 4'h0, 1'b1}, // R6 all locked
    '{6'd9,  28'h200, 4'h0, 1'b1, 4'h1, 3'd1, 1'b0, 4'h0, 1'b0}, // R1
    '{6'd9,  28'h201, 4'h0, 1'b0, 4'h0, 3'd0, 1'b0, 4'h2, 1'b0}, // R4 empty way
    '{6'd9,  28'h201, 4'h2, 1'b0, 4'h0, 3'd0, 1'b0, 4'h1, 1'b0}, // R6 empty locked
    '{6'd9,  28'h000, 4'h0, 1'b0, 4'h0, 3'd0, 1'b0, 4'h2, 1'b0}, // R2 invalid match
    '{6'd12, 28'h300, 4'h0, 1'b0, 4'h0, 3'd0, 1'b1, 4'h4, 1'b0}, // R3 bad way
    '{6'd12, 28'h301, 4'h0, 1'b1, 4'h1, 3'd1, 1'b1, 4'h0, 1'b0}, // R3 flag on hit
    '{6'd12, 28'h399, 4'h4, 1'b0, 4'h0, 3'd0, 1'b1, 4'h8, 1'b0}, // R5 start 2 locked
    '{6'd20, 28'h400, 4'h0, 1'b0, 4'h0, 3'd0, 1'b0, 4'h1, 1'b0}, // R2 reserved
    '{6'd20, 28'h401, 4'h0, 1'b1, 4'h2, 3'd1, 1'b0, 4'h0, 1'b0}, // R1
    '{6'd33, 28'h000, 4'h0, 1'b0, 4'h0, 3'd0, 1'b0, 4'h1, 1'b0}  // R9 untouched set
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input int s, input int w, input logic [TW-1:0] t,
                    input logic [2:0] st, input logic [1:0] rn, input logic [1:0] flip);
    @(negedge clk);
    wr_en = 1'b1; wr_set = 6'(s); wr_way = 2'(w); wr_tag = t;
    wr_state = st; wr_rnd = rn; wr_par = {^st, ^t} ^ flip;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [5:0] s, input logic [TW-1:0] t, input logic [3:0] lk);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = {t, s}; way_lock = lk;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 rs_valid after reset", 32'(rs_valid), 0);
    chk("R8 lk_ready after reset", 32'(lk_ready), 1);

    wr(5, 0, 28'h100, 3'd4, 2'd1, 2'd0);
    wr(5, 1, 28'h101, 3'd3, 2'd2, 2'd0);
    wr(5, 2, 28'h102, 3'd2, 2'd0, 2'd0);
    wr(5, 3, 28'h103, 3'd1, 2'd0, 2'd0);
    wr(9, 0, 28'h200, 3'd1, 2'd0, 2'd0);
    wr(9, 2, 28'h202, 3'd2, 2'd0, 2'd0);
    wr(9, 3, 28'h203, 3'd4, 2'd0, 2'd0);
    wr(12, 0, 28'h301, 3'd1, 2'd2, 2'd0);
    wr(12, 1, 28'h302, 3'd1, 2'd0, 2'd0);
    wr(12, 2, 28'h300, 3'd1, 2'd0, 2'd1);
    wr(12, 3, 28'h303, 3'd1, 2'd0, 2'd0);
    wr(20, 0, 28'h400, 3'd6, 2'd0, 2'd0);
    wr(20, 1, 28'h401, 3'd1, 2'd0, 2'd0);
    wr(20, 2, 28'h402, 3'd1, 2'd0, 2'd0);
    wr(20, 3, 28'h403, 3'd1, 2'd0, 2'd0);

    for (int i = 0; i < 16; i++) begin
      look(VECS[i].s_idx, VECS[i].tg, VECS[i].lk);
      chk("R1 rs_valid", 32'(rs_valid), 1);
      chk("R1 R2 rs_hit", 32'(rs_hit), 32'(VECS[i].hit));
      chk("R1 rs_way", 32'(rs_way), 32'(VECS[i].way));
      chk("R1 rs_state", 32'(rs_state), 32'(VECS[i].st));
      chk("R3 rs_par_err", 32'(rs_par_err), 32'(VECS[i].perr));
      chk("R4 R5 R6 R7 rs_victim", 32'(rs_victim), 32'(VECS[i].vic));
      chk("R6 rs_no_alloc", 32'(rs_no_alloc), 32'(VECS[i].na));
    end

    // R10: write then look up, then overwrite to invalid
    wr(40, 3, 28'h55, 3'd2, 2'd0, 2'd0);
    look(6'd40, 28'h55, 4'h0);
    chk("R10 new entry hit way", 32'(rs_way), 32'h8);
    chk("R10 new entry state", 32'(rs_state), 2);
    wr(40, 3, 28'h55, 3'd0, 2'd0, 2'd0);
    look(6'd40, 28'h55, 4'h0);
    chk("R10 invalidated miss", 32'(rs_hit), 0);
    chk("R10 victim lowest empty", 32'(rs_victim), 32'h1);

    // R8: back-pressure hold
    @(negedge clk);
    rs_ready = 1'b0; lk_valid = 1'b1; lk_addr = {28'h101, 6'd5}; way_lock = 4'h0;
    @(negedge clk);
    lk_addr = {28'h100, 6'd5};
    chk("R8 lk_ready low when stalled", 32'(lk_ready), 0);
    chk("R8 stalled way", 32'(rs_way), 32'h2);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R8 rs_valid held", 32'(rs_valid), 1);
      chk("R8 way held", 32'(rs_way), 32'h2);
      chk("R8 state held", 32'(rs_state), 3);
    end
    rs_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R8 next result way", 32'(rs_way), 32'h1);
    chk("R8 next result state", 32'(rs_state), 4);
    @(negedge clk);
    chk("R8 drained", 32'(rs_valid), 0);

    // R9: reset mid-run clears the arrays
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 rs_valid in reset", 32'(rs_valid), 0);
    rst_n = 1'b1;
    look(6'd5, 28'h100, 4'h0);
    chk("R9 no hit after reset", 32'(rs_hit), 0);
    chk("R9 no parity error after reset", 32'(rs_par_err), 0);
    chk("R9 victim after reset", 32'(rs_victim), 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule